// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. A frame opens with one low start bit, carries between five and eight data bits least significant first, may append a parity bit, and closes with one or two high stop bits. The bit time, data length, parity enable and stop count are runtime inputs, copied into the block when a frame begins, so the surrounding register logic can change them at any time without corrupting the frame on the wire.

A frame starts with a single-cycle load strobe, normally produced by the register decode when software writes the transmit data word. While a frame is on the line the block reports busy and drops any further load strobe. A cancel input, raised by the register logic whenever the control configuration is rewritten, ends the frame at once and returns the line to its idle high level. The line is also held high throughout reset. The transmitter shares nothing with the receive path, so both directions can run together.

Top module: `uart_tx_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tx_o` is 1 and `busy_o` is 0 from the next cycle on, and a frame in progress is lost.
- R2: A `load_i` pulse sampled while `busy_o` is 0 and `cancel_i` is 0 makes `tx_o` 0 (start bit) and `busy_o` 1 in the next cycle.
- R3: Every bit of a frame (start, data, parity, stop) lasts exactly `cfg_clk_div` clock cycles; a value of 0 is treated as 1.
- R4: The number of data bits is 5 + `cfg_len_code` (code 0 gives 5 bits, code 3 gives 8), sent from bit 0 of `load_data_i` upward; higher bits of the word are not sent.
- R5: When `cfg_parity_en` is 1, one parity bit follows the data bits, equal to the XOR of the data bits sent; when 0, no parity bit is sent.
- R6: The frame ends with one high stop bit when `cfg_two_stop` is 0 and two when it is 1; after the last stop bit `busy_o` returns to 0 and `tx_o` stays 1.
- R7: A `load_i` pulse sampled while `busy_o` is 1, including the last cycle of the final stop bit, has no effect on `tx_o` or on the frame.
- R8: `cancel_i` sampled high makes `tx_o` 1 and `busy_o` 0 in the next cycle; a `load_i` in the same cycle as `cancel_i` is ignored.
- R9: The configuration inputs are captured on the accepted load; changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_clk_div | input | DIV_W | Bit time in clock cycles (0 acts as 1) |
| cfg_len_code | input | LEN_W | Data length code: bits = 5 + code |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_two_stop | input | 1 | Two stop bits when 1, one when 0 |
| cancel_i | input | 1 | Abort the frame and idle the line |
| load_i | input | 1 | Start a frame with `load_data_i` |
| load_data_i | input | DATA_W | Word to send |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |

## Verification
Two pairs of events can fall in one cycle: a load strobe landing on the final cycle of the last stop bit, and a load strobe coinciding with a cancel. The first is provoked by holding the load strobe high across several frames, so each new frame may only begin one cycle after the previous one drops busy; the second by raising load and cancel together mid-frame. A behavioural model that expands each accepted load into a per-cycle queue of line levels judges both, comparing line and busy every cycle, and it also checks that configuration changes during a frame leave the queued frame intact.

// File: rtl/uart_tx_pkg.sv
// Package: shared types for the serial frame transmitter.
// Assumes nothing beyond IEEE 1800-2017.
package uart_tx_pkg;

    // Frame sequencing phases; ST_IDLE is the only phase with busy low.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

endpackage

// File: rtl/uart_tx_bittimer.sv
// Module: uart_tx_bittimer
// Counts the length of one bit and pulses bit_end in the last cycle of each bit.
// Assumes: start and stop never coincide; the divisor is copied on start, so
// later changes of div_i do not affect the running frame.
module uart_tx_bittimer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [DIV_W-1:0] div_i,
    output logic             bit_end
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             run_q;
    logic [DIV_W-1:0] div_eff;

    // A divisor of zero is treated as one cycle per bit.
    always_comb div_eff = (div_i == '0) ? DIV_W'(1) : div_i;

    // Last cycle of the current bit.
    always_comb bit_end = run_q && (cnt_q == '0);

    // Down-counter reloaded at every bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            div_q <= DIV_W'(1);
        end else if (start) begin
            run_q <= 1'b1;
            div_q <= div_eff;
            cnt_q <= div_eff - DIV_W'(1);
        end else if (stop) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (bit_end) begin
            cnt_q <= div_q - DIV_W'(1);
        end else if (run_q) begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    // R3: the count never leaves the window of one bit time.
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (div_q != '0) && (cnt_q < div_q));

    // R3: away from a boundary the counter steps down by exactly one.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !bit_end && !start && !stop) |=> (cnt_q == $past(cnt_q) - DIV_W'(1)));

endmodule

// File: rtl/uart_tx_shifter.sv
// Module: uart_tx_shifter
// Holds the word being sent, exposes the current and next data bit, and
// computes the parity of the bits that the selected length will send.
// Assumes: DATA_W >= 2 and DATA_W >= 2**LEN_W.
module uart_tx_shifter #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  len_code_i,
    input  logic              shift,
    output logic              cur_bit,
    output logic              next_bit,
    output logic              parity
);
    localparam int MIN_LEN = DATA_W - (2 ** LEN_W) + 1;

    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    logic [DATA_W-1:0] len_mask;

    // One mask bit per data position: set when the selected length reaches it.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        always_comb len_mask[gi] = (gi < (MIN_LEN + int'(len_code_i)));
    end

    // Shift register and parity captured on load, shifted on data boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= data_i;
            par_q <= ^(data_i & len_mask);
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
        end
    end

    // Bits offered to the sequencer.
    always_comb begin
        cur_bit  = sh_q[0];
        next_bit = sh_q[1];
        parity   = par_q;
    end

endmodule

// File: rtl/uart_tx_core.sv
// Module: uart_tx_core (top)
// Sequences start, data, optional parity and stop bits onto a registered
// idle-high serial line. Configuration is captured on the accepted load.
// Assumes: load_i and cancel_i are synchronous single-cycle or level strobes;
// cancel takes priority over everything except reset.
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_clk_div,
    input  logic [LEN_W-1:0]  cfg_len_code,
    input  logic              cfg_parity_en,
    input  logic              cfg_two_stop,
    input  logic              cancel_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic              tx_o,
    output logic              busy_o
);
    localparam int MIN_LEN = DATA_W - (2 ** LEN_W) + 1;
    localparam int IDX_W   = $clog2(DATA_W);

    tx_state_e        state_q, state_d;
    logic             line_q, line_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] last_q;
    logic             par_en_q;
    logic             two_stop_q;
    logic             stop_idx_q, stop_idx_d;
    logic             accept;
    logic             shift;
    logic             frame_done;
    logic             bit_end;
    logic             cur_bit, next_bit, parity;

    // A load is taken only when idle and not cancelled in the same cycle.
    always_comb accept = load_i && (state_q == ST_IDLE) && !cancel_i;

    uart_tx_bittimer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .stop    (cancel_i || frame_done),
        .div_i   (cfg_clk_div),
        .bit_end (bit_end)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .data_i     (load_data_i),
        .len_code_i (cfg_len_code),
        .shift      (shift),
        .cur_bit    (cur_bit),
        .next_bit   (next_bit),
        .parity     (parity)
    );

    // Next phase, next line level and bit indices.
    always_comb begin
        state_d    = state_q;
        line_d     = line_q;
        idx_d      = idx_q;
        stop_idx_d = stop_idx_q;
        shift      = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                line_d = 1'b1;
                if (accept) begin
                    state_d = ST_START;
                    line_d  = 1'b0;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    state_d = ST_DATA;
                    line_d  = cur_bit;
                    idx_d   = '0;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (idx_q == last_q) begin
                        if (par_en_q) begin
                            state_d = ST_PARITY;
                            line_d  = parity;
                        end else begin
                            state_d    = ST_STOP;
                            line_d     = 1'b1;
                            stop_idx_d = 1'b0;
                        end
                    end else begin
                        idx_d  = idx_q + IDX_W'(1);
                        shift  = 1'b1;
                        line_d = next_bit;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_end) begin
                    state_d    = ST_STOP;
                    line_d     = 1'b1;
                    stop_idx_d = 1'b0;
                end
            end
            ST_STOP: begin
                line_d = 1'b1;
                if (bit_end) begin
                    if (stop_idx_q == two_stop_q) begin
                        state_d    = ST_IDLE;
                        frame_done = 1'b1;
                    end else begin
                        stop_idx_d = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                line_d  = 1'b1;
            end
        endcase
        if (cancel_i) begin
            state_d = ST_IDLE;
            line_d  = 1'b1;
        end
    end

    // Sequencer registers; the line is held high through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            line_q     <= 1'b1;
            idx_q      <= '0;
            stop_idx_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            line_q     <= line_d;
            idx_q      <= idx_d;
            stop_idx_q <= stop_idx_d;
        end
    end

    // Frame format captured at the accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q     <= '0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
        end else if (accept) begin
            last_q     <= IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_len_code);
            par_en_q   <= cfg_parity_en;
            two_stop_q <= cfg_two_stop;
        end
    end

    // Outputs straight from registers.
    always_comb begin
        tx_o   = line_q;
        busy_o = (state_q != ST_IDLE);
    end

    // R1: reset leaves the line idle high and the block not busy.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (tx_o && !busy_o));

    // R2: an accepted load drives the start bit in the next cycle.
    assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o && !cancel_i) |=> (!tx_o && busy_o));

    // R6: stop phase and idle keep the line high.
    assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STOP) || (state_q == ST_IDLE)) |-> tx_o);

    // R7: a load during a frame changes nothing away from a bit boundary.
    assert_load_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && busy_o && !cancel_i && !bit_end) |=> (busy_o && $stable(tx_o)));

    // R8: cancel idles the line in the next cycle.
    assert_cancel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> (tx_o && !busy_o));

    // R3: the line only moves at a bit boundary, a start or a cancel.
    assert_line_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bit_end && !cancel_i) |=> $stable(tx_o));

endmodule

// File: tb/uart_tx_core_test.sv
// Bench: behavioural per-cycle queue model compared with the line every cycle.
module uart_tx_core_test;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 2;
    localparam int DIV_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  cfg_clk_div = 16'd4;
    logic [LEN_W-1:0]  cfg_len_code = 2'd3;
    logic              cfg_parity_en = 1'b0;
    logic              cfg_two_stop = 1'b0;
    logic              cancel_i = 1'b0;
    logic              load_i = 1'b0;
    logic [DATA_W-1:0] load_data_i = '0;
    logic              tx_o;
    logic              busy_o;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    model_live = 1'b0;
    bit    exp_tx = 1'b1;
    bit    exp_busy = 1'b0;
    bit    exp_q[$];

    uart_tx_core #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_clk_div(cfg_clk_div),
        .cfg_len_code(cfg_len_code), .cfg_parity_en(cfg_parity_en),
        .cfg_two_stop(cfg_two_stop), .cancel_i(cancel_i), .load_i(load_i),
        .load_data_i(load_data_i), .tx_o(tx_o), .busy_o(busy_o)
    );

    always #5 clk = ~clk;

    // Expand one frame into line levels, one entry per clock cycle.
    function automatic void build_frame(logic [7:0] d, int code, bit pe, bit ts, int div);
        int  per = (div == 0) ? 1 : div;
        int  nd  = 5 + code;
        bit  par = 1'b0;
        for (int k = 0; k < per; k++) exp_q.push_back(1'b0);
        for (int i = 0; i < nd; i++) begin
            par ^= d[i];
            for (int k = 0; k < per; k++) exp_q.push_back(d[i]);
        end
        if (pe) for (int k = 0; k < per; k++) exp_q.push_back(par);
        for (int s = 0; s < (ts ? 2 : 1); s++)
            for (int k = 0; k < per; k++) exp_q.push_back(1'b1);
    endfunction

    // Reference model advanced at every active edge.
    always @(posedge clk) begin
        model_live <= 1'b1;
        if (!rst_n || cancel_i) begin
            exp_q.delete();
            exp_tx = 1'b1;
            exp_busy = 1'b0;
        end else begin
            if (load_i && !exp_busy)
                build_frame(load_data_i, int'(cfg_len_code), cfg_parity_en,
                            cfg_two_stop, int'(cfg_clk_div));
            if (exp_q.size() > 0) begin
                exp_tx = exp_q.pop_front();
                exp_busy = 1'b1;
            end else begin
                exp_tx = 1'b1;
                exp_busy = 1'b0;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (model_live) begin
            check(tx_o === exp_tx, {cur_req, " line"}, int'(tx_o), int'(exp_tx));
            check(busy_o === exp_busy, {cur_req, " busy"}, int'(busy_o), int'(exp_busy));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_cfg(int div, int code, bit pe, bit ts);
        cfg_clk_div   = DIV_W'(div);
        cfg_len_code  = LEN_W'(code);
        cfg_parity_en = pe;
        cfg_two_stop  = ts;
    endtask

    task automatic pulse_load(logic [7:0] d);
        @(negedge clk);
        load_data_i = d;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 5000 && busy_o; n++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(logic [7:0] d, int div, int code, bit pe, bit ts);
        @(negedge clk);
        set_cfg(div, code, pe, ts);
        pulse_load(d);
        wait_idle();
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check(tx_o === 1'b1, "R1 line in reset", int'(tx_o), 1);
        check(busy_o === 1'b0, "R1 busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R2 R3 R4 R6 8N1";
        @(negedge clk);
        set_cfg(4, 3, 0, 0);
        load_data_i = 8'hA5;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        check(tx_o === 1'b0 && busy_o === 1'b1, "R2 start bit", int'(tx_o), 0);
        wait_idle();

        cur_req = "R4 R5 R6 5 bits parity 2 stop";
        send(8'hF3, 3, 0, 1, 1);
        cur_req = "R4 R5 7 bits parity";
        send(8'h4C, 2, 2, 1, 0);
        cur_req = "R3 divisor zero";
        send(8'h96, 0, 1, 1, 1);
        cur_req = "R3 divisor one";
        send(8'h3B, 1, 3, 0, 1);

        cur_req = "R7 load held across frames";
        @(negedge clk);
        set_cfg(2, 0, 1, 0);
        load_data_i = 8'h1D;
        load_i = 1'b1;
        repeat (60) @(negedge clk);
        load_i = 1'b0;
        wait_idle();

        cur_req = "R8 cancel mid frame";
        @(negedge clk);
        set_cfg(5, 3, 1, 1);
        pulse_load(8'h81);
        repeat (17) @(negedge clk);
        cancel_i = 1'b1;
        load_i = 1'b1;
        load_data_i = 8'h7E;
        @(negedge clk);
        cancel_i = 1'b0;
        load_i = 1'b0;
        check(tx_o === 1'b1 && busy_o === 1'b0, "R8 cancel beats load", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0, "R8 still idle", int'(busy_o), 0);
        cur_req = "R8 frame after cancel";
        send(8'h5A, 3, 2, 0, 0);

        cur_req = "R9 config change during frame";
        @(negedge clk);
        set_cfg(3, 3, 1, 1);
        pulse_load(8'hC6);
        set_cfg(7, 0, 0, 0);
        repeat (10) @(negedge clk);
        set_cfg(1, 1, 1, 0);
        wait_idle();

        cur_req = "R1 reset mid frame";
        @(negedge clk);
        set_cfg(4, 3, 0, 0);
        pulse_load(8'h00);
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(tx_o === 1'b1 && busy_o === 1'b0, "R1 reset aborts", int'(tx_o), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cur_req = "R2 R6 after reset";
        send(8'hFF, 2, 3, 1, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule